// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences the operating mode of a single-wire bus transceiver between three modes: fail-safe, normal and sleep. It takes digital flags for supply presence and supply adequacy, the enable request, transmit data, the live bus level and single-cycle wake requests from separate remote (bus) and local wake filters. It drives the regulator inhibit, the communication and termination enables, the receive-data line and the selector for the strong pull-down on the transmit pin.

The enable request is asynchronous, so it passes through a synchronizer first. A free-running 1 µs tick drives three interval counters. One confirms a rising enable before normal mode is entered. One confirms a falling enable before sleep is entered. The third delays inhibit after the supply becomes adequate. A wake from sleep leaves a request flag low on receive data. A local wake also leaves a source flag on the strong pull-down select. Both flags clear as soon as the enable request is seen high. All outputs are registered.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted or `pwr_up_i` is low, the controller is in fail-safe mode with both wake flags clear. Outputs in that state: `mode_o`=0, `comm_en_o`=0, `rxd_o`=1, `txd_strong_pd_o`=0, `inh_o`=0. The mode encoding is 0 fail-safe, 1 normal, 2 sleep.
- R2: Outside sleep, `inh_o` is high only after `vs_ok_i` has been high continuously for PUP_US ticks. It falls in the cycle after `vs_ok_i` drops.
- R3: In fail-safe, `en_i` held high with `vs_ok_i` high moves the controller to normal mode. This happens between (NORM_US-1)·TICK_DIV and NORM_US·TICK_DIV+8 clock cycles after the rise.
- R4: An `en_i` high pulse shorter than the normal-entry delay leaves the mode unchanged.
- R5: In normal mode, a falling `en_i` while `txd_i` is high moves the controller to sleep within the same window as R3, with SLEEP_US in place of NORM_US. If `en_i` returns high before the delay ends, the controller stays in normal mode. Sleep is reached only from normal mode.
- R6: A falling `en_i` while `txd_i` is low leaves the controller in normal mode.
- R7: In normal mode, `vs_ok_i` low returns the controller to fail-safe in the next cycle.
- R8: In sleep, `inh_o`=0, `comm_en_o`=0, `term_en_o`=0 and `rxd_o`=1, whatever the bus level.
- R9: A `bus_wake_i` pulse in sleep gives fail-safe in the next cycle, with `rxd_o`=0, `txd_strong_pd_o`=0 and `inh_o`=1.
- R10: A `local_wake_i` pulse in sleep gives fail-safe with `rxd_o`=0 and `txd_strong_pd_o`=1. When both wake requests arrive together, the local source wins.
- R11: In fail-safe, `en_i` high clears both wake flags within 4 cycles (`rxd_o`=1, `txd_strong_pd_o`=0), before normal mode is entered.
- R12: In normal mode, `comm_en_o`=1 and `term_en_o`=1, and `rxd_o` equals the inverse of `bus_dom_i` one cycle later.
- R13: Wake requests in fail-safe or normal mode have no effect on the mode, `rxd_o` or `txd_strong_pd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_up_i | input | 1 | Supply present (power-up level reached) |
| vs_ok_i | input | 1 | Supply above undervoltage threshold |
| en_i | input | 1 | Asynchronous mode enable request |
| txd_i | input | 1 | Transmit data level, synchronous |
| bus_dom_i | input | 1 | Bus currently dominant |
| bus_wake_i | input | 1 | Filtered remote wake request pulse |
| local_wake_i | input | 1 | Filtered local wake request pulse |
| mode_o | output | 2 | Current mode: 0 fail-safe, 1 normal, 2 sleep |
| inh_o | output | 1 | Regulator inhibit switch on |
| comm_en_o | output | 1 | Transmit and receive path enabled |
| term_en_o | output | 1 | Bus termination enabled |
| rxd_o | output | 1 | Receive data / wake request (low) |
| txd_strong_pd_o | output | 1 | Strong pull-down on transmit pin (local wake source) |

## Verification
The bench builds the controller with TICK_DIV=4, NORM_US=3, SLEEP_US=5 and PUP_US=6. Every enable debounce and the inhibit delay then finish in a few dozen cycles. This lets each run cycle through many sleep and wake round trips, with random wake sources and random bus levels. The small counts also make the edges of the timing windows reachable: enable pulses one tick short of the delay, and a sleep request cancelled just before it completes.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [1:0] {
    M_FAILSAFE = 2'd0,
    M_NORMAL   = 2'd1,
    M_SLEEP    = 2'd2
  } mode_e;
endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/xmc_tick.sv
module xmc_tick #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = $clog2(DIV);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_q == W'(DIV-1))  cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == W'(DIV-1));
endmodule

// File: rtl/xmc_dly.sv
// Counts ticks while run_i holds; done_o once N ticks seen, clears when run_i drops.
module xmc_dly #(
  parameter int unsigned N = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(N + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!run_i)                        cnt_q <= '0;
    else if (tick_i && cnt_q != W'(N))      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == W'(N));

  // R3
  done_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(tick_i) && $past(run_i));
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 16,
  parameter int unsigned NORM_US     = 7,
  parameter int unsigned SLEEP_US    = 15,
  parameter int unsigned PUP_US      = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       vs_ok_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       bus_dom_i,
  input  logic       bus_wake_i,
  input  logic       local_wake_i,
  output logic [1:0] mode_o,
  output logic       inh_o,
  output logic       comm_en_o,
  output logic       term_en_o,
  output logic       rxd_o,
  output logic       txd_strong_pd_o
);
  mode_e mode_q, mode_d;
  logic  wake_q, wake_d, local_q, local_d;
  logic  en_s, en_q, tick;
  logic  sleep_arm_q;
  logic  norm_done, sleep_done, pup_done;
  logic  inh_d, rxd_d;

  xmc_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i, .rst_ni, .d_i(en_i), .q_o(en_s)
  );

  xmc_tick #(.DIV(TICK_DIV)) u_tick (.clk_i, .rst_ni, .tick_o(tick));

  xmc_dly #(.N(NORM_US)) u_norm_dly (
    .clk_i, .rst_ni, .tick_i(tick), .done_o(norm_done),
    .run_i(mode_q == M_FAILSAFE && en_s && vs_ok_i && pwr_up_i)
  );

  xmc_dly #(.N(SLEEP_US)) u_sleep_dly (
    .clk_i, .rst_ni, .tick_i(tick), .done_o(sleep_done),
    .run_i(sleep_arm_q)
  );

  xmc_dly #(.N(PUP_US)) u_pup_dly (
    .clk_i, .rst_ni, .tick_i(tick), .done_o(pup_done),
    .run_i(pwr_up_i && vs_ok_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_s;
  end

  // Sleep is armed only by an enable falling edge seen with transmit data high.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               sleep_arm_q <= 1'b0;
    else if (mode_q != M_NORMAL || en_s)       sleep_arm_q <= 1'b0;
    else if (en_q && !en_s && txd_i)           sleep_arm_q <= 1'b1;
  end

  always_comb begin
    mode_d  = mode_q;
    wake_d  = wake_q;
    local_d = local_q;
    if (!pwr_up_i) begin
      mode_d  = M_FAILSAFE;
      wake_d  = 1'b0;
      local_d = 1'b0;
    end else begin
      unique case (mode_q)
        M_FAILSAFE: begin
          if (en_s) begin
            wake_d  = 1'b0;
            local_d = 1'b0;
          end
          if (norm_done) mode_d = M_NORMAL;
        end
        M_NORMAL: begin
          if (!vs_ok_i)        mode_d = M_FAILSAFE;
          else if (sleep_done) mode_d = M_SLEEP;
        end
        M_SLEEP: begin
          if (local_wake_i || bus_wake_i) begin
            mode_d  = M_FAILSAFE;
            wake_d  = 1'b1;
            local_d = local_wake_i;
          end
        end
        default: mode_d = M_FAILSAFE;
      endcase
    end
  end

  always_comb begin
    inh_d = (mode_d != M_SLEEP) && pup_done && vs_ok_i && pwr_up_i;
    unique case (mode_d)
      M_NORMAL:   rxd_d = !bus_dom_i;
      M_FAILSAFE: rxd_d = !wake_d;
      default:    rxd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q          <= M_FAILSAFE;
      wake_q          <= 1'b0;
      local_q         <= 1'b0;
      inh_o           <= 1'b0;
      comm_en_o       <= 1'b0;
      term_en_o       <= 1'b1;
      rxd_o           <= 1'b1;
      txd_strong_pd_o <= 1'b0;
    end else begin
      mode_q          <= mode_d;
      wake_q          <= wake_d;
      local_q         <= local_d;
      inh_o           <= inh_d;
      comm_en_o       <= (mode_d == M_NORMAL);
      term_en_o       <= (mode_d != M_SLEEP);
      rxd_o           <= rxd_d;
      txd_strong_pd_o <= (mode_d == M_FAILSAFE) && wake_d && local_d;
    end
  end

  assign mode_o = mode_q;

  // R8
  sleep_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP) |-> (!inh_o && !comm_en_o && !term_en_o && rxd_o));

  // R5
  sleep_from_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP && $past(mode_q) != M_SLEEP) |-> ($past(mode_q) == M_NORMAL));

  // R7
  uv_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORMAL && !vs_ok_i) |=> (mode_q == M_FAILSAFE));

  // R11
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_FAILSAFE && en_s && pwr_up_i)
      |=> (mode_q != M_FAILSAFE || (rxd_o && !txd_strong_pd_o)));

  // R10
  strong_pd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_strong_pd_o |-> (!rxd_o && mode_q == M_FAILSAFE));

  // R12
  comm_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comm_en_o |-> term_en_o);
endmodule

// File: tb/xcvr_mode_ctrl_tb_top.sv
module xcvr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int NU = 3;
  localparam int SU = 5;
  localparam int PU = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_up = 1'b1, vs_ok = 1'b1, en = 1'b0, txd = 1'b1;
  logic bus_dom = 1'b0, bus_wake = 1'b0, local_wake = 1'b0;
  logic [1:0] mode;
  logic inh, comm_en, term_en, rxd, strong_pd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_mode_ctrl #(.TICK_DIV(TD), .NORM_US(NU), .SLEEP_US(SU), .PUP_US(PU)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr_up), .vs_ok_i(vs_ok), .en_i(en),
    .txd_i(txd), .bus_dom_i(bus_dom), .bus_wake_i(bus_wake), .local_wake_i(local_wake),
    .mode_o(mode), .inh_o(inh), .comm_en_o(comm_en), .term_en_o(term_en),
    .rxd_o(rxd), .txd_strong_pd_o(strong_pd)
  );

  function automatic int win_lo(input int n); return (n - 1) * TD; endfunction
  function automatic int win_hi(input int n); return n * TD + 8; endfunction
  function automatic int exp_rxd_normal(input logic b); return int'(!b); endfunction
  function automatic int exp_strong(input int src); return int'(src != 0); endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_win(input string req, input int n, input int lo, input int hi);
    checks++;
    if (n < lo || n > hi) begin
      failures++;
      $display("FAIL %s act=%0d exp=[%0d..%0d]", req, n, lo, hi);
    end
  endtask

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  task automatic wait_mode(input logic [1:0] tgt, input int limit, output int n);
    n = 0;
    while (mode != tgt && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic go_normal();
    int n;
    drive_edge(); en = 1'b1;
    wait_mode(2'd1, 200, n);
  endtask

  task automatic go_sleep();
    int n;
    drive_edge(); txd = 1'b1; en = 1'b0;
    wait_mode(2'd2, 200, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R1 reset state
    #(3*CLK_PERIOD);
    check("R1 mode", mode, 0);
    check("R1 comm_en", comm_en, 0);
    check("R1 rxd", rxd, 1);
    check("R1 strong_pd", strong_pd, 0);
    check("R1 inh", inh, 0);
    drive_edge(); rst_n = 1'b1;

    // R2 inhibit power-up delay
    n = 0;
    while (!inh && n < 200) begin @(negedge clk); n++; end
    check_win("R2 inh delay", n, win_lo(PU), win_hi(PU));

    // R4 short enable pulse
    drive_edge(); en = 1'b1;
    repeat ((NU - 1) * TD - 2) @(posedge clk);
    #1 en = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R4 short en", mode, 0);

    // R3 normal entry delay
    drive_edge(); en = 1'b1;
    wait_mode(2'd1, 200, n);
    check_win("R3 normal delay", n, win_lo(NU), win_hi(NU));
    @(negedge clk);
    check("R12 comm_en", comm_en, 1);
    check("R12 term_en", term_en, 1);
    check("R2 inh in normal", inh, 1);

    // R12 random bus levels
    for (int i = 0; i < 20; i++) begin
      logic b;
      b = 1'($urandom_range(0, 1));
      drive_edge(); bus_dom = b;
      @(posedge clk); @(negedge clk);
      check("R12 rxd follows bus", rxd, exp_rxd_normal(b));
    end

    // R13 wake ignored in normal
    drive_edge(); bus_dom = 1'b1; local_wake = 1'b1; bus_wake = 1'b1;
    drive_edge(); local_wake = 1'b0; bus_wake = 1'b0;
    @(negedge clk);
    check("R13 mode in normal", mode, 1);
    check("R13 rxd in normal", rxd, 0);
    check("R13 strong_pd in normal", strong_pd, 0);
    drive_edge(); bus_dom = 1'b0;

    // R6 enable falls with txd low
    drive_edge(); txd = 1'b0; en = 1'b0;
    repeat (SU * TD + 20) @(posedge clk);
    drive_edge(); txd = 1'b1;
    repeat (SU * TD + 20) @(posedge clk);
    @(negedge clk);
    check("R6 stay normal", mode, 1);
    drive_edge(); en = 1'b1;
    repeat (6) @(posedge clk);

    // R5 cancelled sleep
    drive_edge(); en = 1'b0;
    repeat ((SU - 1) * TD - 4) @(posedge clk);
    #1 en = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R5 sleep cancel", mode, 1);

    // R5 sleep delay
    drive_edge(); en = 1'b0;
    wait_mode(2'd2, 200, n);
    check_win("R5 sleep delay", n, win_lo(SU), win_hi(SU));
    @(negedge clk);
    check("R8 inh", inh, 0);
    check("R8 comm_en", comm_en, 0);
    check("R8 term_en", term_en, 0);
    for (int i = 0; i < 6; i++) begin
      drive_edge(); bus_dom = 1'($urandom_range(0, 1));
      @(posedge clk); @(negedge clk);
      check("R8 rxd in sleep", rxd, 1);
    end
    drive_edge(); bus_dom = 1'b0;

    // R9 remote wake
    drive_edge(); bus_wake = 1'b1;
    drive_edge(); bus_wake = 1'b0;
    @(negedge clk);
    check("R9 mode", mode, 0);
    check("R9 rxd", rxd, 0);
    check("R9 strong_pd", strong_pd, 0);
    check("R9 inh", inh, 1);
    // R13 wake ignored in fail-safe
    drive_edge(); local_wake = 1'b1;
    drive_edge(); local_wake = 1'b0;
    @(negedge clk);
    check("R13 strong_pd in fail-safe", strong_pd, 0);

    // R11 flags clear on enable
    drive_edge(); en = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 rxd cleared", rxd, 1);
    check("R11 mode still fail-safe", mode, 0);
    wait_mode(2'd1, 200, n);

    // R10 / R9 random wake sources
    for (int i = 0; i < 8; i++) begin
      int src;
      src = int'($urandom_range(0, 2));
      go_sleep();
      drive_edge(); bus_wake = (src != 1); local_wake = (src != 0);
      drive_edge(); bus_wake = 1'b0; local_wake = 1'b0;
      @(negedge clk);
      check("R10 wake mode", mode, 0);
      check("R10 wake rxd", rxd, 0);
      check("R10 wake source", strong_pd, exp_strong(src));
      drive_edge(); en = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R11 strong_pd cleared", strong_pd, 0);
      wait_mode(2'd1, 200, n);
    end

    // R7 undervoltage
    drive_edge(); vs_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 uv mode", mode, 0);
    check("R2 uv inh", inh, 0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R7 held in fail-safe", mode, 0);
    drive_edge(); vs_ok = 1'b1;
    wait_mode(2'd1, 200, n);
    check("R3 re-enter normal", mode, 1);

    // R1 supply loss
    drive_edge(); pwr_up = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 pwr loss mode", mode, 0);
    check("R1 pwr loss inh", inh, 0);
    drive_edge(); pwr_up = 1'b1;
    go_normal();
    check("R3 after pwr up", mode, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule